// File: doc/BRIEF.md
# Two-Wire Bus Slave with Program-Cycle Lockout

This block is the serial front end of a multi-channel adjustment device on an I2C-style two-wire bus. It oversamples the clock and data lines with a fast system clock and cleans each line with a synchroniser and a glitch filter. It then recognises start and stop conditions, matches a seven-bit slave address and moves bytes between the bus and a register controller. Data is sent most significant bit first. Outgoing data is open drain: the block only asserts an enable that pulls the data line low, and otherwise leaves it released.

The slave address is a fixed three-bit prefix (parameter) followed by four address pins, so sixteen such devices can share one bus. Bytes written by the master are handed to the controller one at a time, with a flag marking the first byte after the address. Read bytes are requested from the controller one byte ahead of their transmission. The controller marks a write as nonvolatile by raising `nv_mark` while the data bytes arrive. When the stop that closes such a write is seen, the block starts a timed program window. During this window it releases the data line and ignores its own address.

Top module: `twb_slave`

## Requirements
- R1: After reset `sda_oe`, `busy`, `wr_valid` and `rd_req` are all low.
- R2: After a start, the first byte holds the seven-bit address in bits 7..1 (MSB first) and the direction in bit 0 (1 = read, 0 = write). When bits 7..1 equal {PREFIX, addr_pins[3:0]}, the slave pulls SDA low during the 9th clock.
- R3: When the address does not match, the slave gives no acknowledge and ignores all traffic until the next start.
- R4: On a write, every data byte is acknowledged on its 9th clock and presented on `wr_byte` with a one-cycle `wr_valid` pulse. `wr_first` is high only for the first data byte after the address.
- R5: On a read, `rd_req` pulses once per byte to be sent. The byte on `rd_data` is then shifted out MSB first.
- R6: After a read byte, a master acknowledge (SDA low on the 9th clock) causes a further byte to be requested and sent. A master no-acknowledge ends the read without another `rd_req`.
- R7: A start during a transaction abandons it and begins a new address phase.
- R8: A stop returns the slave to idle, and bits clocked without a new start are not acknowledged.
- R9: A stop that closes a write during which `nv_mark` was high raises `busy` for exactly BUSY_CYC system clock cycles.
- R10: While `busy` is high, `sda_oe` stays low, a matching address is not acknowledged and no bytes are delivered. The first start after `busy` falls is served normally.
- R11: A write closed without `nv_mark` leaves `busy` low.
- R12: A pulse on either input shorter than FILT_CYC system clock cycles has no effect; a short low pulse on SDA while SCL is high does not act as a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | When high the pad pulls the data line low |
| addr_pins | input | 4 | Low four bits of the slave address |
| nv_mark | input | 1 | Controller flags the current write as nonvolatile |
| rd_data | input | 8 | Next byte to send, valid after an `rd_req` pulse |
| wr_valid | output | 1 | One-cycle strobe for a received data byte |
| wr_byte | output | 8 | Received data byte |
| wr_first | output | 1 | Marks the first data byte after the address |
| rd_req | output | 1 | One-cycle request for the next read byte |
| busy | output | 1 | Program window in progress |

## Verification
Two events can meet in the same window: a start condition and the expiry of the program window. Whether the address is acknowledged depends on which one the slave sees first. The bench closes a nonvolatile write and immediately sends a start with a matching address inside the window, which must go unacknowledged. It then measures the window length at the port and sends another start as soon as `busy` has dropped, which must be acknowledged. Stop-versus-start ordering is also exercised by aborting transactions mid-byte with a repeated start and with a stop.

// File: rtl/twb_pkg.sv
package twb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDAT,
    ST_WACK,
    ST_RDAT,
    ST_RACK
  } twb_state_e;
endpackage

// File: rtl/twb_line_filter.sv
module twb_line_filter #(
  parameter int FILT_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic clean
);
  localparam int CW = $clog2(FILT_CYC + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] run_q, run_n;
  logic          clean_n;

  always_comb begin
    run_n   = '0;
    clean_n = clean;
    if (sync_q[1] != clean) begin
      if (run_q == CW'(FILT_CYC - 1)) begin
        clean_n = sync_q[1];
      end else begin
        run_n = run_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      run_q  <= '0;
      clean  <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], raw};
      run_q  <= run_n;
      clean  <= clean_n;
    end
  end

  // R12: the clean level only moves after the raw level held for the filter run
  p_filter_run_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (clean != $past(clean)) |-> ($past(run_q) == CW'(FILT_CYC - 1)));
endmodule

// File: rtl/twb_busy_timer.sv
module twb_busy_timer #(
  parameter int BUSY_CYC = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic busy
);
  localparam int CW = $clog2(BUSY_CYC + 1);

  logic [CW-1:0] left_q, left_n;

  always_comb begin
    left_n = left_q;
    if (kick) begin
      left_n = CW'(BUSY_CYC);
    end else if (left_q != '0) begin
      left_n = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left_q <= '0;
    else        left_q <= left_n;
  end

  assign busy = (left_q != '0);

  // R9: remaining count never exceeds the window length
  p_window_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    left_q <= CW'(BUSY_CYC));
endmodule

// File: rtl/twb_slave.sv
module twb_slave
  import twb_pkg::*;
#(
  parameter logic [2:0] PREFIX   = 3'b010,
  parameter int         FILT_CYC = 4,
  parameter int         BUSY_CYC = 250000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [3:0] addr_pins,
  input  logic       nv_mark,
  input  logic [7:0] rd_data,
  output logic       wr_valid,
  output logic [7:0] wr_byte,
  output logic       wr_first,
  output logic       rd_req,
  output logic       busy
);
  localparam int NLINE = 2;

  logic [NLINE-1:0] raw_w, clean_w;
  assign raw_w = {scl_i, sda_i};

  generate
    for (genvar g = 0; g < NLINE; g++) begin : g_line
      twb_line_filter #(.FILT_CYC(FILT_CYC)) u_filt (
        .clk(clk), .rst_n(rst_n), .raw(raw_w[g]), .clean(clean_w[g]));
    end
  endgenerate

  logic scl_f, sda_f, scl_q, sda_q;
  assign scl_f = clean_w[1];
  assign sda_f = clean_w[0];

  logic start_evt, stop_evt, scl_rise, scl_fall;
  assign start_evt = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_evt  = scl_f & scl_q & ~sda_q & sda_f;
  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;

  twb_state_e st_q, st_n;
  logic [3:0] cnt_q, cnt_n;
  logic [7:0] sh_q, sh_n, tx_q, tx_n;
  logic       oe_n, rw_q, rw_n, more_q, more_n;
  logic       wtx_q, wtx_n, nv_q, nv_n, first_n, wv_n, rq_n, kick;

  always_comb begin
    st_n = st_q; cnt_n = cnt_q; sh_n = sh_q; tx_n = tx_q;
    oe_n = sda_oe; rw_n = rw_q; more_n = more_q;
    wtx_n = wtx_q; nv_n = nv_q; first_n = wr_first;
    wv_n = 1'b0; rq_n = 1'b0; kick = 1'b0;
    if (stop_evt) begin
      kick  = wtx_q & nv_q;
      st_n  = ST_IDLE; oe_n = 1'b0; wtx_n = 1'b0; nv_n = 1'b0;
    end else if (start_evt) begin
      st_n  = busy ? ST_IDLE : ST_ADDR;
      cnt_n = '0; oe_n = 1'b0; wtx_n = 1'b0; nv_n = 1'b0;
    end else begin
      if ((st_q == ST_WDAT || st_q == ST_WACK) && nv_mark) nv_n = 1'b1;
      unique case (st_q)
        ST_ADDR, ST_WDAT: begin
          if (scl_rise) begin
            sh_n  = {sh_q[6:0], sda_f};
            cnt_n = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            if (st_q == ST_WDAT) begin
              oe_n = 1'b1; wv_n = 1'b1; st_n = ST_WACK;
            end else if (sh_q[7:1] == {PREFIX, addr_pins}) begin
              oe_n = 1'b1; rw_n = sh_q[0]; rq_n = sh_q[0]; st_n = ST_AACK;
            end else begin
              st_n = ST_IDLE;
            end
          end
        end
        ST_AACK: if (scl_fall) begin
          cnt_n = '0;
          if (rw_q) begin
            tx_n = rd_data; oe_n = ~rd_data[7]; st_n = ST_RDAT;
          end else begin
            oe_n = 1'b0; wtx_n = 1'b1; first_n = 1'b1; st_n = ST_WDAT;
          end
        end
        ST_WACK: if (scl_fall) begin
          oe_n = 1'b0; first_n = 1'b0; cnt_n = '0; st_n = ST_WDAT;
        end
        ST_RDAT: begin
          if (scl_rise) begin
            cnt_n = cnt_q + 1'b1;
          end else if (scl_fall) begin
            if (cnt_q == 4'd8) begin
              oe_n = 1'b0; st_n = ST_RACK;
            end else begin
              tx_n = {tx_q[6:0], 1'b0}; oe_n = ~tx_q[6];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            more_n = ~sda_f; rq_n = ~sda_f;
          end else if (scl_fall) begin
            cnt_n = '0;
            if (more_q) begin
              tx_n = rd_data; oe_n = ~rd_data[7]; st_n = ST_RDAT;
            end else begin
              st_n = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; cnt_q <= '0; sh_q <= '0; tx_q <= '0;
      sda_oe <= 1'b0; rw_q <= 1'b0; more_q <= 1'b0; wtx_q <= 1'b0;
      nv_q <= 1'b0; wr_first <= 1'b0; wr_valid <= 1'b0; rd_req <= 1'b0;
      scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      st_q <= st_n; cnt_q <= cnt_n; sh_q <= sh_n; tx_q <= tx_n;
      sda_oe <= oe_n; rw_q <= rw_n; more_q <= more_n; wtx_q <= wtx_n;
      nv_q <= nv_n; wr_first <= first_n; wr_valid <= wv_n; rd_req <= rq_n;
      scl_q <= scl_f; sda_q <= sda_f;
    end
  end

  assign wr_byte = sh_q;

  twb_busy_timer #(.BUSY_CYC(BUSY_CYC)) u_busy (
    .clk(clk), .rst_n(rst_n), .kick(kick), .busy(busy));

  // R10: data line left released during the program window
  p_quiet_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe);
  // R10: no traffic reaches the controller during the window
  p_no_xfer_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!wr_valid && !rd_req));
  // R9: the window only opens after a stop
  p_busy_after_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_evt));
  // R2: the pull-down is only switched on just after a clock fall
  p_drive_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall));
  // R4: write strobe and read request never coincide
  p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !rd_req);
endmodule

// File: tb/twb_slave_tb.sv
module twb_slave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 25;
  localparam int FILT       = 4;
  localparam int BUSYC      = 300;
  localparam logic [2:0] PFX  = 3'b010;
  localparam logic [3:0] PINS = 4'b1011;

  logic clk, rst_n, scl_m, sda_m, sda_oe, nv_mark, wr_valid, wr_first, rd_req, busy;
  logic [7:0] rd_data, wr_byte;
  logic sda_line;
  assign sda_line = sda_m & ~sda_oe;

  twb_slave #(.PREFIX(PFX), .FILT_CYC(FILT), .BUSY_CYC(BUSYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .addr_pins(PINS), .nv_mark(nv_mark), .rd_data(rd_data), .wr_valid(wr_valid),
    .wr_byte(wr_byte), .wr_first(wr_first), .rd_req(rd_req), .busy(busy));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] cap [0:63];
  logic       capf [0:63];
  int ncap = 0, nreq = 0, rd_idx = 0, run = 0, last_len = 0;
  logic [7:0] pool [0:63];

  always @(negedge clk) begin
    if (wr_valid) begin cap[ncap] = wr_byte; capf[ncap] = wr_first; ncap++; end
    if (rd_req) begin rd_data <= pool[rd_idx]; rd_idx++; nreq++; end
    if (busy) run++;
    else begin if (run != 0) last_len = run; run = 0; end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic qw(); repeat (Q) @(negedge clk); endtask
  task automatic bstart(); sda_m = 1; qw(); scl_m = 1; qw(); sda_m = 0; qw(); scl_m = 0; qw(); endtask
  task automatic bstop(); sda_m = 0; qw(); scl_m = 1; qw(); sda_m = 1; qw(); endtask
  task automatic wbit(input logic b); sda_m = b; qw(); scl_m = 1; qw(); qw(); scl_m = 0; qw(); endtask
  task automatic rbit(output logic b); sda_m = 1; qw(); scl_m = 1; qw(); b = sda_line; qw(); scl_m = 0; qw(); endtask

  task automatic send_byte(input logic [7:0] v, output logic acked);
    logic x;
    for (int i = 7; i >= 0; i--) wbit(v[i]);
    rbit(x);
    acked = (x == 1'b0);
  endtask

  task automatic recv_byte(output logic [7:0] v, input logic ack);
    for (int i = 7; i >= 0; i--) rbit(v[i]);
    wbit(!ack);
  endtask

  function automatic logic [7:0] addr_byte(input logic [3:0] pins, input logic rd);
    return {PFX, pins, rd};
  endfunction

  initial begin
    int w;
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] v;
    int base, len, dummy;
    dummy = $urandom(32'd4242);
    for (int i = 0; i < 64; i++) pool[i] = 8'($urandom);
    scl_m = 1; sda_m = 1; nv_mark = 0; rd_data = 8'h00; rst_n = 0;
    repeat (5) @(negedge clk);
    chk("R1 sda_oe", sda_oe, 0); chk("R1 busy", busy, 0);
    chk("R1 wr_valid", wr_valid, 0); chk("R1 rd_req", rd_req, 0);
    rst_n = 1;
    repeat (10) @(negedge clk);

    // R3: wrong pins, then wrong prefix
    bstart(); send_byte(addr_byte(4'b0011, 0), a); chk("R3 pin mismatch ack", a, 0);
    send_byte(8'h5A, a); chk("R3 ignored byte ack", a, 0); bstop();
    bstart(); send_byte({3'b110, PINS, 1'b0}, a); chk("R3 prefix mismatch ack", a, 0); bstop();
    chk("R3 nothing delivered", ncap, 0);

    // R2 R4 R11: random writes without nonvolatile mark
    for (int t = 0; t < 4; t++) begin
      logic [7:0] d [0:2];
      len = 1 + ($urandom % 3); base = ncap;
      bstart(); send_byte(addr_byte(PINS, 0), a); chk("R2 address ack", a, 1);
      for (int k = 0; k < len; k++) begin
        d[k] = 8'($urandom); send_byte(d[k], a); chk("R4 data ack", a, 1);
      end
      bstop();
      chk("R4 byte count", ncap - base, len);
      for (int k = 0; k < len; k++) begin
        chk("R4 byte value", cap[base+k], d[k]);
        chk("R4 first flag", capf[base+k], (k == 0));
      end
      repeat (20) @(negedge clk);
      chk("R11 no window", busy, 0);
    end

    // R5 R6: reads of random length, last byte refused
    for (int t = 0; t < 3; t++) begin
      int r0, q0;
      len = 1 + ($urandom % 3); r0 = rd_idx; q0 = nreq;
      bstart(); send_byte(addr_byte(PINS, 1), a); chk("R2 read address ack", a, 1);
      for (int k = 0; k < len; k++) begin
        recv_byte(v, k != len - 1);
        chk("R5 read byte", v, pool[r0+k]);
      end
      bstop();
      chk("R6 request count", nreq - q0, len);
    end

    // R7: repeated start after four data bits, then a read
    base = ncap;
    bstart(); send_byte(addr_byte(PINS, 0), a);
    wbit(1); wbit(0); wbit(1); wbit(1);
    bstart(); send_byte(addr_byte(PINS, 1), a); chk("R7 restart ack", a, 1);
    recv_byte(v, 0); chk("R7 read after restart", v, pool[rd_idx-1]);
    bstop(); chk("R7 aborted byte dropped", ncap - base, 0);

    // R8: stop mid-byte, then bits without start
    base = ncap;
    bstart(); send_byte(addr_byte(PINS, 0), a); wbit(1); wbit(0); wbit(0);
    bstop(); scl_m = 0; qw();
    send_byte(addr_byte(PINS, 0), a); chk("R8 no ack after stop", a, 0);
    send_byte(8'h33, a); bstop();
    chk("R8 nothing delivered", ncap - base, 0);

    // R12: short SDA pulse while SCL high must not start a transaction
    repeat (10) @(negedge clk);
    sda_m = 0; repeat (FILT - 2) @(negedge clk); sda_m = 1; qw();
    scl_m = 0; qw();
    send_byte(addr_byte(PINS, 0), a); chk("R12 glitch is not a start", a, 0);
    bstop();
    // R12: short SCL low pulse mid-bit must not clock a bit
    base = ncap;
    bstart(); send_byte(addr_byte(PINS, 0), a);
    sda_m = 0; qw(); scl_m = 1; qw(); scl_m = 0; repeat (FILT - 2) @(negedge clk); scl_m = 1; qw(); scl_m = 0; qw();
    for (int i = 6; i >= 0; i--) wbit(8'hC3 >> i);
    send_byte(8'h00, a);
    bstop();
    chk("R12 byte with clock glitch", cap[base], 8'h43);

    // R9 R10: nonvolatile write, attempt inside window, then after it
    bstart(); send_byte(addr_byte(PINS, 0), a);
    nv_mark = 1; send_byte(8'h9C, a); nv_mark = 0;
    bstop();
    base = ncap;
    chk("R9 window open", busy, 1);
    bstart(); send_byte(addr_byte(PINS, 0), a); chk("R10 no ack in window", a, 0);
    send_byte(8'h11, a); bstop();
    chk("R10 nothing delivered", ncap - base, 0);
    while (busy) @(negedge clk);
    @(negedge clk);
    chk("R9 window length", last_len, BUSYC);
    bstart(); send_byte(addr_byte(PINS, 0), a); chk("R10 ack after window", a, 1);
    bstop();
    repeat (20) @(negedge clk);
    chk("R11 plain write no window", busy, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule